// File: doc/BRIEF.md
# Multi-Lane Sampling-Phase and Word-Boundary Trainer

This block trains a four-lane deserializing receiver for 16-bit converter samples. Each lane is sampled on eight equally spaced clock phases. The front end delivers, on every input beat, one 16-bit word per lane per phase. While the converter sends a known test word, the block does two things for each lane on its own. First it finds the sampling phase that sits in the middle of the widest band of good phases. Then it finds the word-boundary slip, within three bits either side of nominal, that frames the test word correctly. Lanes with different skews therefore end up sampled and framed alike.

Training starts when `train_start` is pulsed. Each lane runs a sequence of windows. A window is one priming beat, which loads the previous-word register, followed by 64 scored beats. There are eight phase windows, then up to seven slip windows. Phase and slip settings change only at window boundaries. After every lane has locked, the block forwards framed words downstream. The input side is valid/ready: `in_ready` stays high throughout training. After lock, `in_ready` drops while a held output word is stalled by `out_ready` low. The output side is a single register stage, and a stalled word keeps its value until it is taken. The source cannot be paused in real hardware, so words offered while `in_ready` is low are lost.

Top module: `lvds_deskew_trainer`

## Requirements
- R1: After reset every lane reports phase 0, slip 0, not done and no error. `all_done` and `out_valid` are low, `out_data` is zero and `in_ready` is high.
- R2: During the phase scan, a phase passes when all 64 scored words equal some circular rotation of `pattern`. The lane then chooses the centre of the longest circular run of passing phases, at index (start + (length-1)/2) mod 8. On a tie, the run with the lowest start index wins. If all eight phases pass, phase 3 is chosen.
- R3: Every lane chooses its phase and slip independently of the other lanes.
- R4: The slip is reported as 3-bit two's complement. With previous word P and current word C, the framed word is bits [k+15:k] of {P,C}, where k = 3 + slip. Slips are tried in order -3 to +3, and the lane locks on the first slip for which all 64 scored framed words equal `pattern`.
- R5: If no phase passes, that lane's error bit is set at the end of the eighth phase window and its done bit stays low.
- R6: If no slip passes, that lane's error bit is set at the end of the seventh slip window and its done bit stays low.
- R7: `all_done` is high only when all four lanes have locked. Until then `out_valid` stays low and `out_data` stays zero.
- R8: A `train_start` pulse clears every lane's phase, slip, done and error state, clears the output, and restarts the search at phase 0.
- R9: A lane's phase and slip change only at the end of a window or on `train_start`.
- R10: After lock, each accepted beat loads the framed words of all lanes into the output, which is visible on the following cycle. While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_data` holds its value.
- R11: A lane that locks on slip index i (0 for -3, up to 6 for +3) reports done after exactly 65·(8+i+1) accepted beats. Cycles with `in_valid` low do not advance the search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| train_start | input | 1 | Single-cycle request to restart training |
| pattern | input | 16 | Expected test word |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| in_words | input | 512 | Word of lane l, phase p at bits [(l*8+p)*16 +: 16] |
| lane_phase | output | 12 | Chosen phase, 3 bits per lane |
| lane_slip | output | 12 | Chosen slip, 3-bit two's complement per lane |
| lane_done | output | 4 | Lane locked |
| lane_err | output | 4 | Lane training failed |
| all_done | output | 1 | All lanes locked |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts output |
| out_data | output | 64 | Framed words, lane l at bits [l*16 +: 16] |

## Verification
On every cycle, the assertions check the following. Settings stay put between window boundaries. The slip stays inside its range. A slip window that ends without a match never locks. A restart clears the lane. The output is never valid before full lock, and a stalled output word holds and back-pressures the input. Only the bench scenarios can show the rest. That covers centre-of-run selection for several phase masks, including a run that wraps and a tie. It also covers the lock beat count for each slip value, the framing of arbitrary words after lock, both failure paths, and the fact that gaps in `in_valid` leave the timing unchanged.

// File: rtl/dsk_pkg.sv
package dsk_pkg;
  typedef enum logic [2:0] {
    TS_IDLE  = 3'd0,
    TS_PHASE = 3'd1,
    TS_SLIP  = 3'd2,
    TS_LOCK  = 3'd3,
    TS_FAIL  = 3'd4
  } trn_state_e;
endpackage

// File: rtl/dsk_lane_framer.sv
module dsk_lane_framer #(
  parameter int W    = 16,
  parameter int NPH  = 8,
  parameter int SMAX = 3,
  localparam int PHW = $clog2(NPH),
  localparam int SW  = $clog2(SMAX + 1) + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 beat,
  input  logic [NPH*W-1:0]     lane_words,
  input  logic [PHW-1:0]       phase_sel,
  input  logic signed [SW-1:0] slip_sel,
  input  logic [W-1:0]         pattern,
  output logic                 rot_hit,
  output logic                 win_hit,
  output logic [W-1:0]         framed
);
  logic [W-1:0]   cur, prev;
  logic [2*W-1:0] dbl;
  logic [W-1:0]   rot_eq;
  int             k;

  assign cur = lane_words[phase_sel*W +: W];
  assign dbl = {cur, cur};

  // previous word on the selected phase, used for boundary slip
  always_ff @(posedge clk) begin
    if (!rst_n)    prev <= '0;
    else if (beat) prev <= cur;
  end

  // framing-agnostic match: any circular rotation of the test word
  for (genvar r = 0; r < W; r++) begin : g_rot
    assign rot_eq[r] = (dbl[r +: W] == pattern);
  end
  assign rot_hit = |rot_eq;

  always_comb k = SMAX + int'(slip_sel);
  assign framed  = W'({prev, cur} >> k);
  assign win_hit = (framed == pattern);
endmodule

// File: rtl/dsk_lane_trainer.sv
module dsk_lane_trainer
  import dsk_pkg::*;
#(
  parameter int NPH  = 8,
  parameter int WIN  = 64,
  parameter int SMAX = 3,
  localparam int PHW = $clog2(NPH),
  localparam int SW  = $clog2(SMAX + 1) + 1,
  localparam int CW  = $clog2(WIN + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 beat,
  input  logic                 rot_hit,
  input  logic                 win_hit,
  output logic [PHW-1:0]       phase_q,
  output logic signed [SW-1:0] slip_q,
  output logic                 done,
  output logic                 err
);
  trn_state_e     st;
  logic [CW-1:0]  cnt;
  logic           ok, score, pass, last;
  logic [NPH-1:0] mask, mask_nx;
  logic [PHW:0]   ctr;

  function automatic logic [PHW:0] pick_center(input logic [NPH-1:0] m);
    int best_len, best_c, len;
    best_len = 0;
    best_c   = 0;
    if (&m) return {1'b1, PHW'((NPH - 1) / 2)};
    for (int s = 0; s < NPH; s++) begin
      if (m[s] && !m[(s + NPH - 1) % NPH]) begin
        len = 0;
        for (int j = 0; j < NPH; j++)
          if (len == j && m[(s + j) % NPH]) len++;
        if (len > best_len) begin
          best_len = len;
          best_c   = (s + (len - 1) / 2) % NPH;
        end
      end
    end
    return {best_len > 0, PHW'(best_c)};
  endfunction

  assign last    = beat && (cnt == CW'(WIN));
  assign score   = (st == TS_PHASE) ? rot_hit : win_hit;
  assign pass    = ok && score;
  assign mask_nx = mask | ({{(NPH-1){1'b0}}, pass} << phase_q);
  assign ctr     = pick_center(mask_nx);
  assign done    = (st == TS_LOCK);
  assign err     = (st == TS_FAIL);

  always_ff @(posedge clk) begin
    if (!rst_n || start) begin
      st      <= start ? TS_PHASE : TS_IDLE;
      cnt     <= '0;
      ok      <= 1'b0;
      mask    <= '0;
      phase_q <= '0;
      slip_q  <= '0;
    end else if (beat && (st == TS_PHASE || st == TS_SLIP)) begin
      if (cnt == '0) begin
        ok  <= 1'b1;                 // priming beat, not scored
        cnt <= CW'(1);
      end else if (!last) begin
        ok  <= ok && score;
        cnt <= cnt + 1'b1;
      end else begin
        cnt <= '0;
        ok  <= 1'b0;
        if (st == TS_PHASE) begin
          mask <= mask_nx;
          if (phase_q == PHW'(NPH - 1)) begin
            if (ctr[PHW]) begin
              phase_q <= ctr[PHW-1:0];
              slip_q  <= -SW'(SMAX);
              st      <= TS_SLIP;
            end else begin
              st <= TS_FAIL;
            end
          end else begin
            phase_q <= phase_q + 1'b1;
          end
        end else begin
          if (pass)                         st <= TS_LOCK;
          else if (slip_q == SW'(SMAX))     st <= TS_FAIL;
          else                              slip_q <= slip_q + 1'b1;
        end
      end
    end
  end

  // R9: settings move only at a window end or on restart
  p_sel_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !last) |=> ($stable(phase_q) && $stable(slip_q)));

  // R4: slip stays inside the correction range
  p_slip_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (slip_q >= -SMAX) && (slip_q <= SMAX));

  // R4: a slip window that ends on a mismatch cannot lock
  p_no_false_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == TS_SLIP && last && !win_hit && !start) |=> !done);

  // R8: restart clears the lane
  p_start_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (phase_q == '0 && slip_q == '0 && !done && !err));
endmodule

// File: rtl/lvds_deskew_trainer.sv
module lvds_deskew_trainer #(
  parameter int LANES = 4,
  parameter int W     = 16,
  parameter int NPH   = 8,
  parameter int WIN   = 64,
  parameter int SMAX  = 3,
  localparam int PHW  = $clog2(NPH),
  localparam int SW   = $clog2(SMAX + 1) + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   train_start,
  input  logic [W-1:0]           pattern,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [LANES*NPH*W-1:0] in_words,
  output logic [LANES*PHW-1:0]   lane_phase,
  output logic [LANES*SW-1:0]    lane_slip,
  output logic [LANES-1:0]       lane_done,
  output logic [LANES-1:0]       lane_err,
  output logic                   all_done,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [LANES*W-1:0]     out_data
);
  logic             beat;
  logic [LANES*W-1:0] framed_all;

  assign all_done = &lane_done;
  assign in_ready = !all_done || !out_valid || out_ready;
  assign beat     = in_valid && in_ready;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic                 rot_hit, win_hit;
    logic [PHW-1:0]       ph;
    logic signed [SW-1:0] sl;

    dsk_lane_framer #(.W(W), .NPH(NPH), .SMAX(SMAX)) u_frm (
      .clk       (clk),
      .rst_n     (rst_n),
      .beat      (beat),
      .lane_words(in_words[l*NPH*W +: NPH*W]),
      .phase_sel (ph),
      .slip_sel  (sl),
      .pattern   (pattern),
      .rot_hit   (rot_hit),
      .win_hit   (win_hit),
      .framed    (framed_all[l*W +: W])
    );

    dsk_lane_trainer #(.NPH(NPH), .WIN(WIN), .SMAX(SMAX)) u_trn (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (train_start),
      .beat   (beat),
      .rot_hit(rot_hit),
      .win_hit(win_hit),
      .phase_q(ph),
      .slip_q (sl),
      .done   (lane_done[l]),
      .err    (lane_err[l])
    );

    assign lane_phase[l*PHW +: PHW] = ph;
    assign lane_slip[l*SW +: SW]    = sl;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || train_start) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (all_done && beat) begin
      out_valid <= 1'b1;
      out_data  <= framed_all;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R7: no output before every lane has locked
  p_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> all_done);

  // R10: stalled output holds its word
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !train_start) |=> (out_valid && $stable(out_data)));

  // R10: stalled output back-pressures the input
  p_bp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

// File: tb/lvds_deskew_trainer_test.sv
`timescale 1ns/1ps
module lvds_deskew_trainer_test;
  localparam int L = 4, P = 8, W = 16;
  localparam logic [W-1:0] PAT = 16'h1E6B;

  logic clk = 1'b0, rst_n = 1'b0, train_start = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic in_ready, all_done, out_valid;
  logic [L*P*W-1:0] in_words = '0;
  logic [L*3-1:0] lane_phase, lane_slip;
  logic [L-1:0] lane_done, lane_err;
  logic [L*W-1:0] out_data;

  int checks = 0, fails = 0, nbeats = 0;
  int lock_at[L], err_at[L];
  logic [7:0]   cmask[L];
  logic [W-1:0] craw[L];
  logic [W-1:0] prevw[L];

  always #4 clk = ~clk;

  lvds_deskew_trainer uut (
    .clk(clk), .rst_n(rst_n), .train_start(train_start), .pattern(PAT),
    .in_valid(in_valid), .in_ready(in_ready), .in_words(in_words),
    .lane_phase(lane_phase), .lane_slip(lane_slip), .lane_done(lane_done),
    .lane_err(lane_err), .all_done(all_done), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  function automatic logic [W-1:0] rotl(input logic [W-1:0] x, input int r);
    logic [2*W-1:0] t;
    t = {x, x} << r;
    return t[2*W-1:W];
  endfunction

  function automatic logic [W-1:0] frame(input logic [W-1:0] p, input logic [W-1:0] c, input int slip);
    logic [2*W-1:0] t;
    t = {p, c} >> (3 + slip);
    return t[W-1:0];
  endfunction

  function automatic logic [L*P*W-1:0] mk(input bit data_mode, input logic [W-1:0] d);
    logic [L*P*W-1:0] r;
    for (int l = 0; l < L; l++)
      for (int p = 0; p < P; p++)
        r[(l*P+p)*W +: W] = data_mode ? d : (cmask[l][p] ? craw[l] : ~PAT);
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic observe();
    for (int l = 0; l < L; l++) begin
      if (lane_done[l] && lock_at[l] < 0) lock_at[l] = nbeats;
      if (lane_err[l]  && err_at[l]  < 0) err_at[l]  = nbeats;
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); train_start = 1'b1; in_valid = 1'b0;
    @(negedge clk); train_start = 1'b0;
    nbeats = 0;
    for (int l = 0; l < L; l++) begin lock_at[l] = -1; err_at[l] = -1; end
  endtask

  task automatic run_train(input int cycles, input bit gappy);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      observe();
      in_valid = gappy ? (i % 3 != 2) : 1'b1;
      in_words = mk(1'b0, '0);
      if (in_valid && in_ready) nbeats++;
    end
    @(negedge clk);
    observe();
    in_valid = 1'b0;
  endtask

  function automatic int lock_beats(input int slip);
    return 65 * (8 + (slip + 3) + 1);
  endfunction

  task automatic t_reset();
    chk(all_done == 0 && out_valid == 0, "R1", "done/valid", {all_done, out_valid}, 0);
    chk(lane_done == 0 && lane_err == 0, "R1", "lane flags", {lane_done, lane_err}, 0);
    chk(lane_phase == 0 && lane_slip == 0, "R1", "settings", {lane_phase, lane_slip}, 0);
    chk(out_data == 0 && in_ready == 1, "R1", "data/ready", out_data, 0);
  endtask

  task automatic t_basic(input bit gappy, input string rq);
    int ex_ph[L] = '{3, 0, 3, 5};
    int ex_sl[L] = '{-3, 3, 0, 1};
    cmask[0] = 8'b0011_1100; cmask[1] = 8'b1000_0011;
    cmask[2] = 8'b1111_1111; cmask[3] = 8'b0111_0110;
    for (int l = 0; l < L; l++) craw[l] = rotl(PAT, 3 + ex_sl[l]);
    pulse_start();
    run_train(gappy ? 1700 : 1100, gappy);
    for (int l = 0; l < L; l++) begin
      chk(lane_phase[l*3 +: 3] == ex_ph[l], "R2", "phase", lane_phase[l*3 +: 3], ex_ph[l]);
      chk($signed(lane_slip[l*3 +: 3]) == ex_sl[l], "R4", "slip", $signed(lane_slip[l*3 +: 3]), ex_sl[l]);
      chk(lock_at[l] == lock_beats(ex_sl[l]), rq, "lock beat", lock_at[l], lock_beats(ex_sl[l]));
      chk(lane_err[l] == 0, "R3", "lane err", lane_err[l], 0);
    end
    chk(all_done == 1, "R7", "all_done", all_done, 1);
    for (int l = 0; l < L; l++) begin
      chk(out_data[l*W +: W] == PAT, "R10", "framed pattern", out_data[l*W +: W], PAT);
      prevw[l] = craw[l];
    end
  endtask

  task automatic t_stream();
    logic [W-1:0] d;
    int sl[L] = '{-3, 3, 0, 1};
    for (int n = 1; n <= 6; n++) begin
      d = 16'h9000 ^ W'(n * 16'h0F31);
      @(negedge clk); in_valid = 1'b1; in_words = mk(1'b1, d);
      @(negedge clk); in_valid = 1'b0;
      for (int l = 0; l < L; l++) begin
        chk(out_data[l*W +: W] == frame(prevw[l], d, sl[l]), "R4", "stream framing",
            out_data[l*W +: W], frame(prevw[l], d, sl[l]));
        prevw[l] = d;
      end
      chk(out_valid == 1, "R10", "out_valid", out_valid, 1);
    end
  endtask

  task automatic t_backpressure();
    logic [L*W-1:0] held;
    int sl[L] = '{-3, 3, 0, 1};
    @(negedge clk); out_ready = 1'b0; in_valid = 1'b1; in_words = mk(1'b1, 16'h5A5A);
    @(negedge clk);
    held = out_data;
    chk(out_valid == 1 && in_ready == 0, "R10", "stall ready", in_ready, 0);
    in_words = mk(1'b1, 16'hC3C3);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(out_data == held && in_ready == 0, "R10", "held word", out_data[15:0], held[15:0]);
    end
    out_ready = 1'b1;
    @(negedge clk); in_valid = 1'b0;
    for (int l = 0; l < L; l++)
      chk(out_data[l*W +: W] == frame(16'h5A5A, 16'hC3C3, sl[l]), "R10", "after release",
          out_data[l*W +: W], frame(16'h5A5A, 16'hC3C3, sl[l]));
  endtask

  task automatic t_failures();
    cmask[0] = 8'b1100_0011; craw[0] = rotl(PAT, 3 + 2);
    cmask[1] = 8'b0011_0011; craw[1] = rotl(PAT, 3 - 1);
    cmask[2] = 8'b0000_0000; craw[2] = PAT;
    cmask[3] = 8'b1111_1111; craw[3] = rotl(PAT, 8);
    pulse_start();
    chk(lane_done == 0 && lane_err == 0, "R8", "flags cleared", {lane_done, lane_err}, 0);
    chk(lane_phase == 0 && lane_slip == 0, "R8", "settings cleared", {lane_phase, lane_slip}, 0);
    chk(out_valid == 0 && out_data == 0, "R8", "output cleared", out_data, 0);
    run_train(1100, 1'b0);
    chk(lane_phase[0 +: 3] == 7, "R2", "wrapping run", lane_phase[0 +: 3], 7);
    chk(lane_phase[3 +: 3] == 0, "R2", "tie lowest start", lane_phase[3 +: 3], 0);
    chk(lock_at[0] == lock_beats(2) && lock_at[1] == lock_beats(-1), "R3", "lanes lock", lock_at[0], lock_beats(2));
    chk(err_at[2] == 520 && lane_done[2] == 0, "R5", "no phase err", err_at[2], 520);
    chk(err_at[3] == 975 && lane_done[3] == 0, "R6", "no slip err", err_at[3], 975);
    chk(all_done == 0 && out_valid == 0 && out_data == 0, "R7", "gated output", out_data, 0);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic(1'b0, "R11");
    t_stream();
    t_backpressure();
    t_failures();
    t_basic(1'b1, "R11");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule